// File: doc/BRIEF.md
# Link Request Serial Stream Transmitter

This block turns a link-layer service request into a framed serial bit stream. The stream goes out on one request line toward a physical-layer device, one bit per clock. A request arrives on a parallel command interface with a valid/ready handshake. It carries a 3-bit kind code and the operands that kind needs: a speed code, a register address, write data or an acceleration enable. The block builds the frame for that kind. It shifts the frame out with frame bit 0 first, then lets the line fall back to low.

There are four bus-request kinds: immediate, isochronous, priority and fair. Register read, register write and arbitration-acceleration control each have their own frame layout. Frames differ in length by kind. A bus request drops its trailing stop bit when its last speed bit is 0. The reserved kind code is consumed without sending anything, and it raises a one-cycle error pulse. The busy output is high for exactly the cycles in which frame bits are on the line.

Top module: `req_line_tx`

## Requirements
- R1: After reset and whenever no frame is being sent, reqLine is 0, busy is 0, cmdReady is 1 and errPulse is 0.
- R2: In the cycle after a non-reserved command is accepted (cmdValid and cmdReady both high at a clock edge), reqLine carries frame bit 0, which is 1. Each later frame bit follows one cycle after the one before it. The last bit of every frame is 0.
- R3: Frame bits 1 to 3 carry the kind code, most significant bit first. The codes are: 000 immediate, 001 isochronous, 010 priority, 011 fair, 100 register read, 101 register write, 110 acceleration control, 111 reserved.
- R4: A bus request (kind codes 000 to 011) with cmdSpeed[0]=1 is 8 bits: 1, kind[2:0], cmdSpeed[2:0] most significant bit first, then a 0 stop bit.
- R5: A bus request with cmdSpeed[0]=0 is 7 bits: 1, kind[2:0], cmdSpeed[2:0]. It has no stop bit.
- R6: A register read (100) is 9 bits: 1, 100, cmdAddr[3:0] most significant bit first, then 0.
- R7: A register write (101) is 17 bits: 1, 101, cmdAddr[3:0], cmdData[7:0], each most significant bit first, then 0.
- R8: An acceleration control request (110) is 6 bits: 1, 110, cmdAccelEn, then 0.
- R9: A command with kind 111 is accepted while cmdReady is high but sends no frame. errPulse is 1 for the single cycle after acceptance. busy stays 0 and reqLine stays 0.
- R10: cmdReady is 0 and busy is 1 from the cycle after acceptance through the cycle that drives the last frame bit, and for no other cycle. With cmdValid held high, at least one cycle with reqLine 0 separates consecutive frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Command can be taken this cycle |
| cmdType | input | 3 | Request kind code |
| cmdSpeed | input | 3 | Speed code for bus requests |
| cmdAddr | input | 4 | Register address for read/write |
| cmdData | input | 8 | Register write data |
| cmdAccelEn | input | 1 | Acceleration enable for acceleration control |
| reqLine | output | 1 | Serial request line, low when idle |
| busy | output | 1 | Frame bits are being driven |
| errPulse | output | 1 | One-cycle pulse after a reserved-kind command |

## Verification
The hardest case to reach from the ports is a second command waiting while a frame is still being sent. It must be taken only after the last bit, and exactly one low cycle must be left on the line before the next start bit. The bench holds cmdValid high across a whole register-read frame and changes the operands to an acceleration request as soon as the first command is taken. It then checks the line bit by bit across the gap. Short bus frames are also exercised with a zero last speed bit, so that they end on a speed bit rather than a stop bit.

// File: rtl/req_line_pkg.sv
package req_line_pkg;
  localparam int TYPE_W = 3;

  typedef enum logic [TYPE_W-1:0] {
    KIND_IMM    = 3'b000,
    KIND_ISO    = 3'b001,
    KIND_PRI    = 3'b010,
    KIND_FAIR   = 3'b011,
    KIND_REG_RD = 3'b100,
    KIND_REG_WR = 3'b101,
    KIND_ACCEL  = 3'b110,
    KIND_RSVD   = 3'b111
  } reqKind_e;

  typedef struct packed {
    logic load;
    logic shift;
  } seqStrobe_t;
endpackage

// File: rtl/req_frame_build.sv
module req_frame_build
  import req_line_pkg::*;
#(
  parameter int SPEED_W = 3,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8,
  localparam int FRAME_W = 2 + TYPE_W + ADDR_W + DATA_W,
  localparam int LEN_W   = $clog2(FRAME_W + 1)
) (
  input  logic [TYPE_W-1:0]  kindIn,
  input  logic [SPEED_W-1:0] speedIn,
  input  logic [ADDR_W-1:0]  addrIn,
  input  logic [DATA_W-1:0]  dataIn,
  input  logic               accelIn,
  output logic [FRAME_W-1:0] frameOut,
  output logic [LEN_W-1:0]   frameLen,
  output logic               isReserved
);
  // index of frame bit 4 inside the left-aligned vector
  localparam int PAY_HI  = FRAME_W - 2 - TYPE_W;
  localparam int BUS_LEN = 1 + TYPE_W + SPEED_W;
  localparam int RD_LEN  = 2 + TYPE_W + ADDR_W;
  localparam int AC_LEN  = 3 + TYPE_W;

  reqKind_e kind;
  assign kind = reqKind_e'(kindIn);

  always_comb begin
    frameOut = '0;
    frameOut[FRAME_W-1] = 1'b1;
    frameOut[FRAME_W-2 -: TYPE_W] = kindIn;
    frameLen = '0;
    isReserved = 1'b0;
    unique case (kind)
      KIND_IMM, KIND_ISO, KIND_PRI, KIND_FAIR: begin
        frameOut[PAY_HI -: SPEED_W] = speedIn;
        frameLen = speedIn[0] ? LEN_W'(BUS_LEN + 1) : LEN_W'(BUS_LEN);
      end
      KIND_REG_RD: begin
        frameOut[PAY_HI -: ADDR_W] = addrIn;
        frameLen = LEN_W'(RD_LEN);
      end
      KIND_REG_WR: begin
        frameOut[PAY_HI -: ADDR_W] = addrIn;
        frameOut[PAY_HI-ADDR_W -: DATA_W] = dataIn;
        frameLen = LEN_W'(FRAME_W);
      end
      KIND_ACCEL: begin
        frameOut[PAY_HI] = accelIn;
        frameLen = LEN_W'(AC_LEN);
      end
      default: begin
        isReserved = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/req_line_ctrl.sv
module req_line_ctrl
  import req_line_pkg::*;
#(
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmdValid,
  input  logic             isReserved,
  input  logic [LEN_W-1:0] frameLen,
  output seqStrobe_t       strobes,
  output logic             cmdReady,
  output logic             busy,
  output logic             errPulse
);
  typedef enum logic {ST_IDLE, ST_SEND} ctrlState_e;

  ctrlState_e state;
  logic [LEN_W-1:0] bitsLeft;
  logic accept;

  assign cmdReady = (state == ST_IDLE);
  assign busy     = (state == ST_SEND);
  assign accept   = cmdValid && cmdReady;

  always_comb begin
    strobes.load  = accept && !isReserved;
    strobes.shift = busy;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bitsLeft <= '0;
      errPulse <= 1'b0;
    end else begin
      errPulse <= accept && isReserved;
      case (state)
        ST_IDLE: begin
          if (strobes.load) begin
            bitsLeft <= frameLen;
            state    <= ST_SEND;
          end
        end
        default: begin
          bitsLeft <= bitsLeft - LEN_W'(1);
          if (bitsLeft == LEN_W'(1)) state <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/req_line_dp.sv
module req_line_dp
  import req_line_pkg::*;
#(
  parameter int FRAME_W = 17
) (
  input  logic               clk,
  input  logic               rst_n,
  input  seqStrobe_t         strobes,
  input  logic [FRAME_W-1:0] frameIn,
  output logic               reqLine
);
  logic [FRAME_W-1:0] shReg;

  // bits below the frame are zero, so the line falls low once the frame is out
  always_ff @(posedge clk) begin
    if (!rst_n)             shReg <= '0;
    else if (strobes.load)  shReg <= frameIn;
    else if (strobes.shift) shReg <= {shReg[FRAME_W-2:0], 1'b0};
  end

  assign reqLine = shReg[FRAME_W-1];
endmodule

// File: rtl/req_line_tx.sv
module req_line_tx
  import req_line_pkg::*;
#(
  parameter int SPEED_W = 3,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8,
  localparam int FRAME_W = 2 + TYPE_W + ADDR_W + DATA_W,
  localparam int LEN_W   = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmdValid,
  output logic               cmdReady,
  input  logic [TYPE_W-1:0]  cmdType,
  input  logic [SPEED_W-1:0] cmdSpeed,
  input  logic [ADDR_W-1:0]  cmdAddr,
  input  logic [DATA_W-1:0]  cmdData,
  input  logic               cmdAccelEn,
  output logic               reqLine,
  output logic               busy,
  output logic               errPulse
);
  logic [FRAME_W-1:0] frame;
  logic [LEN_W-1:0]   frameLen;
  logic               isReserved;
  seqStrobe_t         strobes;

  req_frame_build #(.SPEED_W(SPEED_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_build (
    .kindIn(cmdType), .speedIn(cmdSpeed), .addrIn(cmdAddr), .dataIn(cmdData),
    .accelIn(cmdAccelEn), .frameOut(frame), .frameLen(frameLen), .isReserved(isReserved)
  );

  req_line_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .isReserved(isReserved),
    .frameLen(frameLen), .strobes(strobes), .cmdReady(cmdReady), .busy(busy),
    .errPulse(errPulse)
  );

  req_line_dp #(.FRAME_W(FRAME_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .frameIn(frame), .reqLine(reqLine)
  );
endmodule

// File: rtl/req_line_tx_chk.sv
module req_line_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmdValid,
  input logic       cmdReady,
  input logic [2:0] cmdType,
  input logic       reqLine,
  input logic       busy,
  input logic       errPulse
);
  logic takeFrame, takeRsvd;
  assign takeFrame = cmdValid && cmdReady && (cmdType != 3'b111);
  assign takeRsvd  = cmdValid && cmdReady && (cmdType == 3'b111);

  AST_IDLE_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !reqLine);  // R1
  AST_START_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    takeFrame |=> (reqLine && busy));  // R2
  AST_LAST_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !$past(reqLine));  // R2
  AST_KIND_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    takeFrame |=> ##1 (reqLine == $past(cmdType[2], 2)));  // R3
  AST_RSVD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    takeRsvd |=> (errPulse && !busy && !reqLine));  // R9
  AST_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmdReady);  // R10
  AST_GAP_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (cmdReady && !reqLine));  // R10
endmodule

bind req_line_tx req_line_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdReady(cmdReady),
  .cmdType(cmdType), .reqLine(reqLine), .busy(busy), .errPulse(errPulse)
);

// File: tb/req_line_tx_bench.sv
module req_line_tx_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmdValid = 1'b0;
  logic cmdReady;
  logic [2:0] cmdType = '0;
  logic [2:0] cmdSpeed = '0;
  logic [3:0] cmdAddr = '0;
  logic [7:0] cmdData = '0;
  logic cmdAccelEn = 1'b0;
  logic reqLine, busy, errPulse;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  req_line_tx u_req_line_tx (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdType(cmdType), .cmdSpeed(cmdSpeed), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .cmdAccelEn(cmdAccelEn), .reqLine(reqLine), .busy(busy), .errPulse(errPulse)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // expected frame, left aligned in 32 bits, built from the requirements
  function automatic void expFrame(input logic [2:0] t, input logic [2:0] sp,
      input logic [3:0] a, input logic [7:0] d, input logic en,
      output logic [31:0] v, output int n);
    case (t)
      3'b100: begin v = {1'b1, t, a, 1'b0, 23'b0};    n = 9;  end
      3'b101: begin v = {1'b1, t, a, d, 1'b0, 15'b0}; n = 17; end
      3'b110: begin v = {1'b1, t, en, 1'b0, 26'b0};   n = 6;  end
      default: begin v = {1'b1, t, sp, 1'b0, 24'b0};  n = sp[0] ? 8 : 7; end
    endcase
  endfunction

  task automatic runFrame(input string req, input logic [2:0] t, input logic [2:0] sp,
      input logic [3:0] a, input logic [7:0] d, input logic en);
    logic [31:0] v;
    int n;
    expFrame(t, sp, a, d, en, v, n);
    @(negedge clk);
    check(cmdReady == 1'b1, "R1", "ready before command", int'(cmdReady), 1);
    cmdValid = 1'b1; cmdType = t; cmdSpeed = sp; cmdAddr = a; cmdData = d; cmdAccelEn = en;
    @(negedge clk);
    cmdValid = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (i > 0) @(negedge clk);
      check(reqLine == v[31-i], req, $sformatf("frame bit %0d", i), int'(reqLine), int'(v[31-i]));
      check(busy && !cmdReady, "R10", $sformatf("busy/ready at bit %0d", i),
            int'({busy, cmdReady}), 2);
    end
    @(negedge clk);
    check(!reqLine && !busy && cmdReady, "R10",
          "idle after last bit (line,busy,ready)", int'({reqLine, busy, cmdReady}), 1);
  endtask

  task automatic testReset();
    @(negedge clk);
    check(!reqLine, "R1", "line low after reset", int'(reqLine), 0);
    check(!busy, "R1", "busy low after reset", int'(busy), 0);
    check(cmdReady, "R1", "ready high after reset", int'(cmdReady), 1);
    check(!errPulse, "R1", "no error after reset", int'(errPulse), 0);
  endtask

  task automatic testReserved();
    @(negedge clk);
    cmdValid = 1'b1; cmdType = 3'b111; cmdSpeed = 3'b111; cmdAddr = 4'hF;
    check(cmdReady, "R9", "reserved command offered while ready", int'(cmdReady), 1);
    @(negedge clk);
    cmdValid = 1'b0;
    check(errPulse, "R9", "error pulse after reserved", int'(errPulse), 1);
    check(!busy && !reqLine, "R9", "no frame for reserved (busy,line)",
          int'({busy, reqLine}), 0);
    @(negedge clk);
    check(!errPulse, "R9", "error pulse lasts one cycle", int'(errPulse), 0);
    check(!busy && !reqLine, "R9", "still idle after reserved", int'({busy, reqLine}), 0);
  endtask

  task automatic testBackToBack();
    logic [31:0] v;
    int n;
    expFrame(3'b100, 3'b000, 4'b0101, 8'h00, 1'b0, v, n);
    @(negedge clk);
    cmdValid = 1'b1; cmdType = 3'b100; cmdAddr = 4'b0101;
    @(negedge clk);
    cmdType = 3'b110; cmdAccelEn = 1'b1;   // second command waits with valid held
    for (int i = 0; i < n; i++) begin
      if (i > 0) @(negedge clk);
      check(reqLine == v[31-i], "R6", $sformatf("b2b first frame bit %0d", i),
            int'(reqLine), int'(v[31-i]));
      check(!cmdReady, "R10", $sformatf("not ready while sending bit %0d", i),
            int'(cmdReady), 0);
    end
    @(negedge clk);
    check(!reqLine && cmdReady && !busy, "R10", "gap cycle between frames",
          int'({reqLine, cmdReady, busy}), 2);
    @(negedge clk);
    cmdValid = 1'b0;
    expFrame(3'b110, 3'b000, 4'b0, 8'h00, 1'b1, v, n);
    for (int i = 0; i < n; i++) begin
      if (i > 0) @(negedge clk);
      check(reqLine == v[31-i], "R8", $sformatf("b2b second frame bit %0d", i),
            int'(reqLine), int'(v[31-i]));
    end
    @(negedge clk);
    check(!busy && !reqLine, "R10", "idle after second frame", int'({busy, reqLine}), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    testReset();
    runFrame("R4", 3'b000, 3'b101, 4'h0, 8'h00, 1'b0);      // immediate, 8 bits
    runFrame("R5", 3'b001, 3'b010, 4'h0, 8'h00, 1'b0);      // isochronous, 7 bits
    runFrame("R5", 3'b010, 3'b000, 4'h0, 8'h00, 1'b0);      // priority, 7 bits
    runFrame("R3", 3'b011, 3'b111, 4'h0, 8'h00, 1'b0);      // fair, 8 bits
    runFrame("R6", 3'b100, 3'b000, 4'b1010, 8'h00, 1'b0);   // register read
    runFrame("R7", 3'b101, 3'b000, 4'b0110, 8'b10110011, 1'b0);
    runFrame("R7", 3'b101, 3'b000, 4'hF, 8'h00, 1'b0);
    runFrame("R8", 3'b110, 3'b000, 4'h0, 8'h00, 1'b1);
    runFrame("R8", 3'b110, 3'b000, 4'h0, 8'h00, 1'b0);
    testReserved();
    runFrame("R2", 3'b001, 3'b001, 4'h0, 8'h00, 1'b0);      // works after reserved
    testBackToBack();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule